// File: doc/BRIEF.md
# Link word CRC-6 and parity guard

This block protects every data word that crosses a serial video link, and it has one half for each end of the link. The transmit half takes a payload word. In checked mode it computes a 6-bit CRC over that word, places the CRC directly above the payload and then adds one even-parity bit on top. The next stage uses that parity bit to find word boundaries. The result goes on to a byte-splitting and line-coding stage. The receive half takes the reassembled word and recomputes the CRC. It checks both the CRC and the parity. When either one fails, it pulses an error flag and increments a saturating error counter.

A width-select input picks the narrow frame (22 bits below parity) or the wide frame (30 bits below parity). In checked mode, 6 of those bits carry the CRC, which leaves 16 or 24 payload bits. When checking is off, the full 22 or 30 bits carry payload and only the parity bit is added. In that case only parity errors are counted.

Top module: `link_word_guard`

## Requirements
- R1: With `crc_en_i`=1 and `wide_i`=0, `tx_word_o` holds the payload (`tx_data_i[15:0]`) in bits [15:0], its CRC in bits [21:16] and the parity bit in bit 22. Bits above 22 are zero. Input bits above the payload are ignored. The word and `tx_valid_o` appear one clock after `tx_valid_i`.
- R2: With `crc_en_i`=1 and `wide_i`=1, `tx_word_o` holds payload bits [23:0], the CRC in [29:24] and parity in bit 30.
- R3: The CRC uses generator x^6+x+1. It has an all-zero start value and takes the payload MSB first. For the narrow payload 0x0001 the CRC is 0x03, so the transmitted word is 0x430001.
- R4: The parity bit makes the total number of ones in the transmitted word even. It covers the payload, the CRC and the parity bit itself, and it sits at bit 22 (narrow) or bit 30 (wide).
- R5: With `crc_en_i`=0, the payload is bits [21:0] (narrow) or [29:0] (wide), with parity at bit 22 or bit 30 and no CRC.
- R6: One clock after `rx_valid_i`, `rx_valid_o` rises. At the same time `rx_data_o` shows the received payload field, zero-extended, with the CRC field removed. Received bits above the parity position are ignored.
- R7: In checked mode, a received CRC field that differs from the CRC recomputed over the received payload raises `rx_err_o` together with `rx_valid_o`. With `crc_en_i`=0 the CRC is not checked.
- R8: A received word whose bits up to and including the parity position hold an odd number of ones raises `rx_err_o`, in either mode.
- R9: `err_cnt_o` rises by one on the same edge that raises `rx_err_o` and stays at 255 once it gets there.
- R10: `err_clr_i` sampled high clears `err_cnt_o` to zero on the next edge, even when an error arrives in the same cycle.
- R11: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | Frame width select: 0 narrow, 1 wide |
| crc_en_i | input | 1 | Enables CRC insertion and checking |
| err_clr_i | input | 1 | Synchronous clear of the error counter |
| tx_valid_i | input | 1 | Transmit payload valid |
| tx_data_i | input | 30 | Transmit payload, LSB aligned |
| tx_valid_o | output | 1 | Transmit word valid |
| tx_word_o | output | 31 | Protected word sent to line coding |
| rx_valid_i | input | 1 | Received word valid |
| rx_word_i | input | 31 | Received protected word |
| rx_valid_o | output | 1 | Received payload valid |
| rx_data_o | output | 30 | Received payload, zero-extended |
| rx_err_o | output | 1 | One-cycle CRC or parity error flag |
| err_cnt_o | output | 8 | Saturating error count |

## Verification
The bench builds the block with its default parameters: a 22-bit narrow frame, a 30-bit wide frame and an 8-bit counter. With these values all four width and check combinations run in one build. The 8-bit counter also lets saturation at 255 be reached with a few hundred corrupted words. The corruption cases are chosen so that parity alone cannot see them: a payload bit is flipped and the parity bit is repaired, which leaves the CRC as the only detector. The same corruption in unchecked mode confirms that the CRC field is then ignored.

// File: rtl/lwg_pkg.sv
package lwg_pkg;
  localparam int CRC_W    = 6;
  localparam int NARROW_W = 22;
  localparam int WIDE_W   = 30;
  localparam int CNT_W    = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 6'h03; // x^6 + x + 1, leading term implied

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic d);
    logic fb;
    fb = c[CRC_W-1] ^ d;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/lwg_crc.sv
module lwg_crc #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]          data_i,
  output logic [lwg_pkg::CRC_W-1:0]  crc_o
);
  always_comb begin
    crc_o = '0;
    for (int i = DATA_W - 1; i >= 0; i--) crc_o = lwg_pkg::crc_step(crc_o, data_i[i]);
  end
endmodule

// File: rtl/lwg_crc_sel.sv
module lwg_crc_sel #(
  parameter int NW = lwg_pkg::NARROW_W,
  parameter int WW = lwg_pkg::WIDE_W
) (
  input  logic                          wide_i,
  input  logic [WW-lwg_pkg::CRC_W-1:0]  payload_i,
  output logic [lwg_pkg::CRC_W-1:0]     crc_o
);
  localparam int NP = NW - lwg_pkg::CRC_W;
  localparam int WP = WW - lwg_pkg::CRC_W;

  logic [lwg_pkg::CRC_W-1:0] crc_n, crc_w;

  lwg_crc #(.DATA_W(NP)) u_crc_n (.data_i(payload_i[NP-1:0]), .crc_o(crc_n));
  lwg_crc #(.DATA_W(WP)) u_crc_w (.data_i(payload_i),         .crc_o(crc_w));

  assign crc_o = wide_i ? crc_w : crc_n;
endmodule

// File: rtl/lwg_tx.sv
module lwg_tx #(
  parameter int NW = lwg_pkg::NARROW_W,
  parameter int WW = lwg_pkg::WIDE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wide_i,
  input  logic          crc_en_i,
  input  logic          valid_i,
  input  logic [WW-1:0] data_i,
  output logic          valid_o,
  output logic [WW:0]   word_o
);
  localparam int CW = lwg_pkg::CRC_W;

  int                dat_w, pay_w;
  logic [WW-1:0]     payload, body;
  logic [CW-1:0]     crc;
  logic [WW:0]       word_n;

  always_comb begin
    dat_w   = wide_i ? WW : NW;
    pay_w   = dat_w - (crc_en_i ? CW : 0);
    payload = data_i & ({WW{1'b1}} >> (WW - pay_w));
  end

  lwg_crc_sel #(.NW(NW), .WW(WW)) u_crc (
    .wide_i   (wide_i),
    .payload_i(payload[WW-CW-1:0]),
    .crc_o    (crc)
  );

  always_comb begin
    body          = payload | (crc_en_i ? (WW'(crc) << pay_w) : '0);
    word_n        = {1'b0, body};
    word_n[dat_w] = ^body; // even parity over payload and CRC
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) word_o <= word_n;
    end
  end
endmodule

// File: rtl/lwg_rx.sv
module lwg_rx #(
  parameter int NW = lwg_pkg::NARROW_W,
  parameter int WW = lwg_pkg::WIDE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wide_i,
  input  logic          crc_en_i,
  input  logic          valid_i,
  input  logic [WW:0]   word_i,
  output logic          hit_o,
  output logic          valid_o,
  output logic [WW-1:0] data_o,
  output logic          err_o
);
  localparam int CW = lwg_pkg::CRC_W;

  int             dat_w, pay_w;
  logic [WW-1:0]  body, payload;
  logic [CW-1:0]  crc_rx, crc_calc;
  logic           par_rx, par_bad, crc_bad;

  always_comb begin
    dat_w   = wide_i ? WW : NW;
    pay_w   = dat_w - (crc_en_i ? CW : 0);
    body    = word_i[WW-1:0] & ({WW{1'b1}} >> (WW - dat_w));
    par_rx  = word_i[dat_w];
    payload = body & ({WW{1'b1}} >> (WW - pay_w));
    crc_rx  = CW'(body >> pay_w);
  end

  lwg_crc_sel #(.NW(NW), .WW(WW)) u_crc (
    .wide_i   (wide_i),
    .payload_i(payload[WW-CW-1:0]),
    .crc_o    (crc_calc)
  );

  assign par_bad = (^body) ^ par_rx;
  assign crc_bad = crc_en_i && (crc_calc != crc_rx);
  assign hit_o   = valid_i && (par_bad || crc_bad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      err_o   <= hit_o;
      if (valid_i) data_o <= payload;
    end
  end
endmodule

// File: rtl/lwg_err_cnt.sv
module lwg_err_cnt #(
  parameter int CNT_W = lwg_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_o <= '0;
    else if (clr_i)                       cnt_o <= '0;
    else if (hit_i && cnt_o != '1)        cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/link_word_guard.sv
module link_word_guard #(
  parameter int NW    = lwg_pkg::NARROW_W,
  parameter int WW    = lwg_pkg::WIDE_W,
  parameter int CNT_W = lwg_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wide_i,
  input  logic             crc_en_i,
  input  logic             err_clr_i,
  input  logic             tx_valid_i,
  input  logic [WW-1:0]    tx_data_i,
  output logic             tx_valid_o,
  output logic [WW:0]      tx_word_o,
  input  logic             rx_valid_i,
  input  logic [WW:0]      rx_word_i,
  output logic             rx_valid_o,
  output logic [WW-1:0]    rx_data_o,
  output logic             rx_err_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  logic rx_hit;

  lwg_tx #(.NW(NW), .WW(WW)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wide_i  (wide_i),
    .crc_en_i(crc_en_i),
    .valid_i (tx_valid_i),
    .data_i  (tx_data_i),
    .valid_o (tx_valid_o),
    .word_o  (tx_word_o)
  );

  lwg_rx #(.NW(NW), .WW(WW)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wide_i  (wide_i),
    .crc_en_i(crc_en_i),
    .valid_i (rx_valid_i),
    .word_i  (rx_word_i),
    .hit_o   (rx_hit),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o),
    .err_o   (rx_err_o)
  );

  lwg_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (err_clr_i),
    .hit_i (rx_hit),
    .cnt_o (err_cnt_o)
  );
endmodule

// File: rtl/lwg_chk.sv
module lwg_chk #(
  parameter int WW    = lwg_pkg::WIDE_W,
  parameter int CNT_W = lwg_pkg::CNT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_valid_i,
  input logic             tx_valid_o,
  input logic [WW:0]      tx_word_o,
  input logic             rx_valid_i,
  input logic             rx_valid_o,
  input logic             rx_err_o,
  input logic             err_clr_i,
  input logic [CNT_W-1:0] err_cnt_o
);
  // R1
  tx_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> tx_valid_o);
  // R1
  tx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_i |=> !tx_valid_o);
  // R4
  tx_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (^tx_word_o) == 1'b0);
  // R6
  rx_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> rx_valid_o);
  // R7
  err_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |-> rx_valid_o);
  // R9
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_clr_i && err_cnt_o != {CNT_W{1'b1}}) |=>
      err_cnt_o == $past(err_cnt_o) + CNT_W'(rx_err_o));
  // R9
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_clr_i && err_cnt_o == {CNT_W{1'b1}}) |=> err_cnt_o == {CNT_W{1'b1}});
  // R10
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i |=> err_cnt_o == '0);
endmodule

bind link_word_guard lwg_chk #(.WW(WW), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_valid_i(tx_valid_i),
  .tx_valid_o(tx_valid_o),
  .tx_word_o (tx_word_o),
  .rx_valid_i(rx_valid_i),
  .rx_valid_o(rx_valid_o),
  .rx_err_o  (rx_err_o),
  .err_clr_i (err_clr_i),
  .err_cnt_o (err_cnt_o)
);

// File: tb/link_word_guard_tb.sv
`timescale 1ns/1ps
module link_word_guard_tb;
  localparam int NW = 22, WW = 30, CW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, wide = 1'b0, crc_en = 1'b0, err_clr = 1'b0;
  logic tx_valid = 1'b0, rx_valid = 1'b0;
  logic [WW-1:0] tx_data = '0;
  logic [WW:0]   rx_word = '0;
  logic          tx_valid_o, rx_valid_o, rx_err_o;
  logic [WW:0]   tx_word_o;
  logic [WW-1:0] rx_data_o;
  logic [CW-1:0] err_cnt_o;

  link_word_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .crc_en_i(crc_en), .err_clr_i(err_clr),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_valid_o(tx_valid_o), .tx_word_o(tx_word_o),
    .rx_valid_i(rx_valid), .rx_word_i(rx_word), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .rx_err_o(rx_err_o), .err_cnt_o(err_cnt_o)
  );

  int checks = 0, errors = 0, exp_cnt = 0;
  logic [WW:0]    tx_q[$];
  string          tx_t[$];
  logic [WW+CW:0] rx_q[$];
  string          rx_t[$];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_crc(logic [WW-1:0] d, int n);
    logic [5:0] c;
    logic fb;
    c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      fb = c[5] ^ d[i];
      c  = {c[4:0], 1'b0};
      if (fb) c = c ^ 6'h03;
    end
    return c;
  endfunction

  function automatic int dw(logic w); return w ? WW : NW; endfunction
  function automatic int pw(logic w, logic c); return dw(w) - (c ? 6 : 0); endfunction
  function automatic logic [WW:0] msk(int n); return (WW+1)'((64'd1 << n) - 1); endfunction

  function automatic logic [WW:0] ref_tx(logic [WW-1:0] d, logic w, logic c);
    logic [WW:0] r;
    int p;
    p = pw(w, c);
    r = {1'b0, d} & msk(p);
    if (c) r = r | ((WW+1)'(ref_crc(d, p)) << p);
    r[dw(w)] = ^r;
    return r;
  endfunction

  task automatic send_tx(logic [WW-1:0] d, logic w, logic c, string tag);
    @(negedge clk);
    wide = w; crc_en = c; tx_valid = 1'b1; tx_data = d; rx_valid = 1'b0; err_clr = 1'b0;
    tx_q.push_back(ref_tx(d, w, c));
    tx_t.push_back(tag);
  endtask

  task automatic send_rx(logic [WW:0] word, logic w, logic c, logic clr, string tag);
    int p;
    logic crc_bad, par_bad, err;
    p = pw(w, c);
    crc_bad = c && (ref_crc(word[WW-1:0], p) != 6'((word >> p) & 31'h3f));
    par_bad = ^(word & msk(dw(w) + 1));
    err = crc_bad || par_bad;
    @(negedge clk);
    wide = w; crc_en = c; rx_valid = 1'b1; rx_word = word; tx_valid = 1'b0; err_clr = clr;
    if (clr) exp_cnt = 0;
    else if (err && exp_cnt < 255) exp_cnt++;
    rx_q.push_back({word[WW-1:0] & msk(p), err, CW'(exp_cnt)});
    rx_t.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    tx_valid = 1'b0; rx_valid = 1'b0; err_clr = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid_o) begin
        if (tx_q.size() == 0) check("R1 spurious tx", 1, 0);
        else check(tx_t.pop_front(), 64'(tx_word_o), 64'(tx_q.pop_front()));
      end
      if (rx_valid_o) begin
        if (rx_q.size() == 0) check("R6 spurious rx", 1, 0);
        else check(rx_t.pop_front(), 64'({rx_data_o, rx_err_o, err_cnt_o}), 64'(rx_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [WW-1:0] pats[4] = '{30'h0, 30'h3fffffff, 30'h1234abcd, 30'h0000a5a5};

  initial begin
    logic [WW:0] g;
    repeat (3) @(negedge clk);
    check("R11 reset tx_valid", tx_valid_o, 0);
    check("R11 reset tx_word", tx_word_o, 0);
    check("R11 reset rx", {rx_valid_o, rx_err_o, rx_data_o}, 0);
    check("R11 reset cnt", err_cnt_o, 0);
    rst_n = 1'b1;

    // R3 known value
    send_tx(30'h1, 1'b0, 1'b1, "R3 crc x^6+x+1");
    idle();
    check("R3 literal word", tx_word_o, 31'h430001);

    foreach (pats[i]) send_tx(pats[i], 1'b0, 1'b1, "R1 R4 narrow crc");
    foreach (pats[i]) send_tx(pats[i], 1'b1, 1'b1, "R2 R4 wide crc");
    foreach (pats[i]) send_tx(pats[i], 1'b0, 1'b0, "R5 narrow plain");
    foreach (pats[i]) send_tx(pats[i], 1'b1, 1'b0, "R5 wide plain");
    idle();

    // good words in all modes, plus junk above parity
    for (int m = 0; m < 4; m++) begin
      foreach (pats[i]) send_rx(ref_tx(pats[i], m[0], m[1]), m[0], m[1], 1'b0, "R6 clean rx");
    end
    g = ref_tx(30'h00abcd, 1'b0, 1'b1);
    send_rx(g | 31'h7f800000, 1'b0, 1'b1, 1'b0, "R6 upper bits ignored");

    // payload flip with parity repaired: only CRC sees it
    g = ref_tx(30'h00abcd, 1'b0, 1'b1);
    send_rx(g ^ 31'h1 ^ (31'h1 << NW), 1'b0, 1'b1, 1'b0, "R7 narrow crc mismatch");
    g = ref_tx(30'h123456, 1'b1, 1'b1);
    send_rx(g ^ 31'h4 ^ (31'h1 << WW), 1'b1, 1'b1, 1'b0, "R7 wide crc mismatch");
    g = ref_tx(30'h00abcd, 1'b0, 1'b1);
    send_rx(g ^ (31'h1 << 16) ^ (31'h1 << NW), 1'b0, 1'b1, 1'b0, "R7 crc field flip");
    g = ref_tx(30'h00abcd, 1'b0, 1'b0);
    send_rx(g ^ (31'h1 << 17) ^ (31'h1 << NW), 1'b0, 1'b0, 1'b0, "R7 no crc check when off");

    // parity flips
    for (int m = 0; m < 4; m++) begin
      g = ref_tx(30'h2468ace, m[0], m[1]);
      send_rx(g ^ ((WW+1)'(1) << dw(m[0])), m[0], m[1], 1'b0, "R8 parity flip");
    end
    g = ref_tx(30'h0, 1'b1, 1'b0);
    send_rx(g ^ 31'h8, 1'b1, 1'b0, 1'b0, "R8 data flip plain");

    // saturation
    for (int k = 0; k < 260; k++) begin
      g = ref_tx(30'(k), 1'b1, 1'b1);
      send_rx(g ^ ((WW+1)'(1) << WW), 1'b1, 1'b1, 1'b0, "R9 saturating count");
    end
    idle();
    check("R9 held at 255", err_cnt_o, 8'd255);

    // clear together with an error
    g = ref_tx(30'h55, 1'b0, 1'b1);
    send_rx(g ^ (31'h1 << NW), 1'b0, 1'b1, 1'b1, "R10 clear beats error");
    send_rx(g ^ (31'h1 << NW), 1'b0, 1'b1, 1'b0, "R10 count after clear");
    @(negedge clk);
    tx_valid = 1'b0; rx_valid = 1'b0; err_clr = 1'b1;
    exp_cnt = 0;
    idle();
    check("R10 plain clear", err_cnt_o, 0);

    repeat (3) idle();
    check("R6 rx queue drained", rx_q.size(), 0);
    check("R1 tx queue drained", tx_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule